// File: doc/BRIEF.md
# Configuration Cycle Forwarding Decoder

This block sits on the primary side of a PCI-to-PCI bridge. It looks at the address phase of a Type 1 configuration cycle and decides what the bridge should place on its secondary bus. There are four outcomes. The cycle may become a Type 0 cycle that drives one IDSEL line. It may be forwarded untouched as a Type 1 cycle toward a deeper bus. It may become a special cycle. Or it may be left alone.

Inputs are the primary address word, the bus command, a strobe that marks the address phase, and the bridge's secondary and subordinate bus numbers. The block has one register stage. One clock after the strobe it presents four results:

- the secondary address word,
- a two-bit forwarding kind,
- a flag that limits a converted cycle to a single 32-bit data phase,
- a flag saying that no device will claim the cycle, so it will end in a master abort.

Bus signalling, queuing of delayed transactions and data movement are handled elsewhere.

Top module: `cfg_fwd_top`

## Requirements
- R1: A cycle qualifies when address bits 1:0 are 01b and the command is 1010b (read) or 1011b (write). A qualifying cycle whose bus number (address bits 23:16) equals the secondary bus number, and that is not a special cycle, gives kind 01b (Type 0). For device number n from 0 to 15 (address bits 15:11), secondary address bit 16+n is 1 and the rest of bits 31:16 are 0. Bits 15:2 are copied unchanged and bits 1:0 become 00b.
- R2: On a Type 0 result with device number 16 to 31, bits 31:16 of the secondary address are all zero. The kind is still 01b and bits 15:2 are still copied unchanged.
- R3: The master-abort flag is 1 exactly when the kind is 01b and no IDSEL bit is set, that is for device numbers 16 to 31. It is 0 for every other result.
- R4: A qualifying cycle to the secondary bus number with device number 31 and register number (address bits 7:2) equal to zero gives kind 11b (special cycle), an all-zero secondary address, and both flags at 0. Device 31 with a nonzero register number follows R2 and R3 instead.
- R5: The single-data-phase flag is 1 exactly when the kind is 01b.
- R6: A qualifying cycle whose bus number is strictly greater than the secondary bus number and less than or equal to the subordinate bus number gives kind 10b (pass-through). The secondary address equals the primary address bit for bit, and both flags are 0.
- R7: Any other command, any other value of address bits 1:0, or a bus number outside the window gives kind 00b (ignore), with an all-zero address and both flags at 0.
- R8: All outputs take the decision for the inputs present at the clock edge where the strobe is high, and become visible after that edge. While the strobe is low the outputs hold their values, whatever the other inputs do.
- R9: While reset is asserted, and until the first strobe after reset is released, the outputs are kind 00b, an all-zero address and both flags at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_strobe_i | input | 1 | Marks the address phase; the inputs are sampled when it is high |
| pri_ad_i | input | 32 | Primary address word |
| cmd_i | input | 4 | Bus command |
| sec_bus_i | input | 8 | Secondary bus number |
| sub_bus_i | input | 8 | Subordinate bus number |
| sec_ad_o | output | 32 | Translated secondary address |
| kind_o | output | 2 | Forwarding kind: 00 ignore, 01 Type 0, 10 pass-through, 11 special cycle |
| single_o | output | 1 | Limit the cycle to one 32-bit data phase |
| abort_o | output | 1 | No IDSEL is driven, so a master abort is expected |

## Verification
Every result is due on the first rising edge after the strobe goes high, because one register stands between the inputs and the outputs. The reset release passes through a two-flop synchronizer, so the bench waits several clocks after releasing reset before the first strobe. The bench raises the strobe on a falling edge and drops it on the next falling edge. It compares all outputs at that same falling edge, half a clock after the capturing edge. Hold behaviour is checked by changing the inputs with the strobe low and sampling again one and two edges later.

// File: rtl/cfg_fwd_pkg.sv
package cfg_fwd_pkg;
  localparam int AD_W      = 32;
  localparam int BUS_W     = 8;
  localparam int DEV_W     = 5;
  localparam int REG_W     = 6;
  localparam int CMD_W     = 4;
  localparam int IDSEL_LO  = 16;
  localparam int IDSEL_N   = AD_W - IDSEL_LO;
  localparam int BUS_LO    = 16;
  localparam int DEV_LO    = 11;
  localparam int REG_LO    = 2;
  localparam logic [CMD_W-1:0] CMD_CFG_RD = 4'b1010;
  localparam logic [CMD_W-1:0] CMD_CFG_WR = 4'b1011;
  localparam logic [1:0]       TYPE1_TAG  = 2'b01;

  typedef enum logic [1:0] {
    FWD_IGNORE  = 2'b00,
    FWD_TYPE0   = 2'b01,
    FWD_PASS    = 2'b10,
    FWD_SPECIAL = 2'b11
  } fwd_kind_t;
endpackage

// File: rtl/cfg_fwd_classify.sv
module cfg_fwd_classify
  import cfg_fwd_pkg::*;
(
  input  logic [AD_W-1:0]  ad_i,
  input  logic [CMD_W-1:0] cmd_i,
  input  logic [BUS_W-1:0] sec_i,
  input  logic [BUS_W-1:0] sub_i,
  output fwd_kind_t        kind_o
);
  localparam logic [DEV_W-1:0] DEV_BCAST = {DEV_W{1'b1}};

  logic [BUS_W-1:0] bus;
  logic [DEV_W-1:0] dev;
  logic [REG_W-1:0] regn;
  logic             qual;
  logic             local_bus;
  logic             in_window;

  always_comb begin
    bus       = ad_i[BUS_LO +: BUS_W];
    dev       = ad_i[DEV_LO +: DEV_W];
    regn      = ad_i[REG_LO +: REG_W];
    qual      = (ad_i[1:0] == TYPE1_TAG) &&
                ((cmd_i == CMD_CFG_RD) || (cmd_i == CMD_CFG_WR));
    local_bus = (bus == sec_i);
    in_window = (bus > sec_i) && (bus <= sub_i);
    if (qual && local_bus) begin
      if ((dev == DEV_BCAST) && (regn == '0)) kind_o = FWD_SPECIAL;
      else                                    kind_o = FWD_TYPE0;
    end else if (qual && in_window) begin
      kind_o = FWD_PASS;
    end else begin
      kind_o = FWD_IGNORE;
    end
  end
endmodule

// File: rtl/cfg_fwd_idsel.sv
module cfg_fwd_idsel
  import cfg_fwd_pkg::*;
(
  input  logic [DEV_W-1:0]   dev_i,
  output logic [IDSEL_N-1:0] idsel_o,
  output logic               hit_o
);
  for (genvar i = 0; i < IDSEL_N; i++) begin : g_line
    assign idsel_o[i] = (dev_i == DEV_W'(i));
  end
  assign hit_o = |idsel_o;
endmodule

// File: rtl/cfg_fwd_top.sv
module cfg_fwd_top
  import cfg_fwd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             addr_strobe_i,
  input  logic [31:0]      pri_ad_i,
  input  logic [3:0]       cmd_i,
  input  logic [7:0]       sec_bus_i,
  input  logic [7:0]       sub_bus_i,
  output logic [31:0]      sec_ad_o,
  output logic [1:0]       kind_o,
  output logic             single_o,
  output logic             abort_o
);
  logic [1:0]         rst_sync;
  logic               rst_q_n;
  fwd_kind_t          kind_d;
  logic [IDSEL_N-1:0] idsel;
  logic               idsel_hit;
  logic [AD_W-1:0]    ad_nxt;
  logic [1:0]         kind_nxt;
  logic               single_nxt;
  logic               abort_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  cfg_fwd_classify u_classify (
    .ad_i   (pri_ad_i),
    .cmd_i  (cmd_i),
    .sec_i  (sec_bus_i),
    .sub_i  (sub_bus_i),
    .kind_o (kind_d)
  );

  cfg_fwd_idsel u_idsel (
    .dev_i   (pri_ad_i[DEV_LO +: DEV_W]),
    .idsel_o (idsel),
    .hit_o   (idsel_hit)
  );

  always_comb begin
    ad_nxt     = '0;
    kind_nxt   = kind_d;
    single_nxt = 1'b0;
    abort_nxt  = 1'b0;
    unique case (kind_d)
      FWD_TYPE0: begin
        ad_nxt     = {idsel, pri_ad_i[IDSEL_LO-1:2], 2'b00};
        single_nxt = 1'b1;
        abort_nxt  = ~idsel_hit;
      end
      FWD_PASS:    ad_nxt = pri_ad_i;
      FWD_SPECIAL: ad_nxt = '0;
      default:     ad_nxt = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      sec_ad_o <= '0;
      kind_o   <= FWD_IGNORE;
      single_o <= 1'b0;
      abort_o  <= 1'b0;
    end else if (addr_strobe_i) begin
      sec_ad_o <= ad_nxt;
      kind_o   <= kind_nxt;
      single_o <= single_nxt;
      abort_o  <= abort_nxt;
    end
  end
endmodule

// File: rtl/cfg_fwd_chk.sv
module cfg_fwd_chk
  import cfg_fwd_pkg::*;
(
  input logic        clk,
  input logic        rst_q_n,
  input logic        addr_strobe_i,
  input logic [31:0] pri_ad_i,
  input logic [31:0] sec_ad_o,
  input logic [1:0]  kind_o,
  input logic        single_o,
  input logic        abort_o
);
  // R1: a Type 0 result that does not abort drives exactly one IDSEL line
  a_r1_onehot_idsel: assert property (@(posedge clk) disable iff (!rst_q_n)
    (kind_o == FWD_TYPE0 && !abort_o) |-> ($countones(sec_ad_o[31:16]) == 1));

  // R3: an abort flag means no IDSEL line is driven
  a_r3_abort_no_idsel: assert property (@(posedge clk) disable iff (!rst_q_n)
    abort_o |-> (kind_o == FWD_TYPE0 && sec_ad_o[31:16] == 16'h0));

  // R5: the single-phase flag follows the Type 0 kind
  a_r5_single_type0: assert property (@(posedge clk) disable iff (!rst_q_n)
    single_o == (kind_o == FWD_TYPE0));

  // R6: pass-through reproduces the sampled primary address
  a_r6_pass_copy: assert property (@(posedge clk) disable iff (!rst_q_n)
    (addr_strobe_i ##1 kind_o == FWD_PASS) |-> (sec_ad_o == $past(pri_ad_i)));

  // R7: an ignore result carries nothing
  a_r7_ignore_quiet: assert property (@(posedge clk) disable iff (!rst_q_n)
    (kind_o == FWD_IGNORE) |-> (sec_ad_o == 32'h0 && !single_o && !abort_o));

  // R8: without a strobe the outputs hold
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_q_n)
    !addr_strobe_i |=> ($stable(sec_ad_o) && $stable(kind_o) &&
                        $stable(single_o) && $stable(abort_o)));
endmodule

bind cfg_fwd_top cfg_fwd_chk u_chk (
  .clk           (clk),
  .rst_q_n       (rst_q_n),
  .addr_strobe_i (addr_strobe_i),
  .pri_ad_i      (pri_ad_i),
  .sec_ad_o      (sec_ad_o),
  .kind_o        (kind_o),
  .single_o      (single_o),
  .abort_o       (abort_o)
);

// File: tb/tb_cfg_fwd_top.sv
module tb_cfg_fwd_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        strobe;
  logic [31:0] ad;
  logic [3:0]  cmd;
  logic [7:0]  sec, sub;
  logic [31:0] sec_ad;
  logic [1:0]  kind;
  logic        single, abort_f;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_fwd_top dut (
    .clk(clk), .rst_n(rst_n), .addr_strobe_i(strobe), .pri_ad_i(ad),
    .cmd_i(cmd), .sec_bus_i(sec), .sub_bus_i(sub),
    .sec_ad_o(sec_ad), .kind_o(kind), .single_o(single), .abort_o(abort_f)
  );

  function automatic logic [35:0] expect_of(logic [31:0] a, logic [3:0] c,
                                            logic [7:0] s, logic [7:0] u);
    logic       q;
    logic [7:0] b;
    logic [4:0] d;
    q = (a[1:0] == 2'b01) && (c == 4'ha || c == 4'hb);
    b = a[23:16];
    d = a[15:11];
    if (q && b == s) begin
      if (d == 5'd31 && a[7:2] == 6'd0) return {32'h0, 2'b11, 1'b0, 1'b0};
      if (d < 5'd16) return {(32'h1 << (16 + d)) | (a & 32'h0000_fffc), 2'b01, 1'b1, 1'b0};
      return {a & 32'h0000_fffc, 2'b01, 1'b1, 1'b1};
    end
    if (q && b > s && b <= u) return {a, 2'b10, 1'b0, 1'b0};
    return 36'h0;
  endfunction

  task automatic check(string tag, logic [35:0] exp);
    logic [35:0] got;
    got = {sec_ad, kind, single, abort_f};
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got ad=%h kind=%b s=%b a=%b, expected ad=%h kind=%b s=%b a=%b",
               tag, got[35:4], got[3:2], got[1], got[0],
               exp[35:4], exp[3:2], exp[1], exp[0]);
    end
  endtask

  task automatic apply(string tag, logic [31:0] a, logic [3:0] c,
                       logic [7:0] s, logic [7:0] u);
    @(negedge clk);
    ad = a; cmd = c; sec = s; sub = u; strobe = 1'b1;
    @(negedge clk);
    strobe = 1'b0;
    check(tag, expect_of(a, c, s, u));
  endtask

  function automatic logic [31:0] mk(logic [7:0] b, logic [4:0] d,
                                     logic [2:0] f, logic [5:0] r, logic [1:0] t);
    return {8'h5a, b, d, f, r, t};
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    total++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [35:0] held;
    rst_n = 1'b0; strobe = 1'b0; ad = '0; cmd = '0; sec = '0; sub = '0;
    repeat (3) @(negedge clk);
    check("R9 reset", 36'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R9 after release", 36'h0);

    // R1 R2 R3 R5: all device numbers, two register numbers
    for (int d = 0; d < 32; d++) begin
      apply(d < 16 ? "R1 onehot" : "R2 R3 no idsel",
            mk(8'h05, 5'(d), 3'(d), 6'h2d, 2'b01), 4'ha, 8'h05, 8'h09);
      apply("R5 zero reg", mk(8'h05, 5'(d), 3'd7, 6'h00, 2'b01), 4'hb, 8'h05, 8'h09);
    end
    // R4: special cycle and its near misses
    apply("R4 special", mk(8'h05, 5'd31, 3'd3, 6'h00, 2'b01), 4'ha, 8'h05, 8'h09);
    apply("R4 reg nonzero", mk(8'h05, 5'd31, 3'd0, 6'h01, 2'b01), 4'ha, 8'h05, 8'h09);
    // R6 R7: sweep of every bus number
    for (int b = 0; b < 256; b++)
      apply("R6 R7 window", mk(8'(b), 5'd3, 3'd1, 6'h11, 2'b01), 4'hb, 8'h05, 8'h09);
    apply("R6 upper edge", mk(8'hff, 5'd2, 3'd0, 6'h04, 2'b01), 4'ha, 8'h00, 8'hff);
    // R7: every command, every low-bit value
    for (int c = 0; c < 16; c++)
      for (int t = 0; t < 4; t++) begin
        apply("R7 qualify", mk(8'h05, 5'd4, 3'd2, 6'h08, 2'(t)), 4'(c), 8'h05, 8'h09);
        apply("R7 qualify pass", mk(8'h07, 5'd4, 3'd2, 6'h08, 2'(t)), 4'(c), 8'h05, 8'h09);
      end
    // R8: hold while the strobe is low
    apply("R8 load", mk(8'h05, 5'd9, 3'd5, 6'h3f, 2'b01), 4'ha, 8'h05, 8'h09);
    held = expect_of(mk(8'h05, 5'd9, 3'd5, 6'h3f, 2'b01), 4'ha, 8'h05, 8'h09);
    ad = mk(8'h07, 5'd1, 3'd0, 6'h00, 2'b01); cmd = 4'hb;
    @(negedge clk);
    check("R8 hold 1", held);
    ad = 32'h0; cmd = 4'h0;
    @(negedge clk);
    check("R8 hold 2", held);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule